// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master that runs exactly one serial-flash command each time software starts it. A command is made of an opcode byte, an optional run of transmit bytes, and an optional run of receive bytes. The transmit bytes come from a shared byte buffer. Received bytes go back into that same buffer, directly after the transmitted ones. Software loads the opcode, sets the two byte counts through an index/data register pair, fills the buffer, and sets the execute bit. It then polls until both the execute and busy indications have dropped, rewinds the buffer pointer and reads the response.

A flash address is not a separate field. Software places it in the buffer as three bytes, most significant first, and includes those three bytes in the transmit count. A command with both counts at zero sends only the opcode, for example a write-enable of 0x06. The serial side uses a single data line in each direction, SPI mode 0, most significant bit first. The serial clock comes from the system clock through a programmable half-period divider.

The host port has six byte registers. Address 0 is the opcode. Address 1 is control/status. Address 2 is the extension index. Address 3 is the extension data. Address 4 is the buffer data window. Address 5 is the clock divider. Host accesses complete in one cycle, and read data is combinational from the address.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` and `spi_mosi` are 0, control/status (address 1) reads 0, both byte counts read 0 and the divider (address 5) reads 1.
- R2: With both counts at zero, one frame of exactly 8 bits carries only the opcode (address 0), most significant bit first.
- R3: With transmit count T, the opcode is followed by buffer bytes 0..T-1 in order. Each bit is driven while `spi_sclk` is low and is held across its rising edge (mode 0), and a frame lasts 8*(1+T+R) clocks.
- R4: With receive count R, R further bytes are clocked with `spi_mosi` held 0. Response byte i is sampled on rising edges, MSB first, and stored at buffer offset T+i, leaving offsets below T unchanged.
- R5: Writing address 3 sets the transmit count when address 2 holds 5 and the receive count when it holds 6. Reading address 3 returns the selected count, and any other index reads 0 and ignores writes.
- R6: Writing control bit 0 starts a command. Status bit 0 (execute) and bit 1 (busy) read 1 from the next cycle until the cycle in which `spi_cs_n` returns high, and both fall together; an execute write while busy starts nothing.
- R7: `spi_cs_n` falls one half-period before the first rising `spi_sclk` edge and rises one half-period after the last falling edge. `spi_sclk` is low whenever `spi_cs_n` is high.
- R8: Each `spi_sclk` half-period lasts D system cycles, where D is the divider value and a value of 0 acts as 1.
- R9: Control bit 1 rewinds the buffer pointer to 0. Each write or read of address 4 while idle accesses the byte at the pointer and then advances the pointer by one.
- R10: A count write above 72 stores 72, and starting with T+R above 72 cuts R to 72-T. Either event sets status bit 2, which stays set until a control write with bit 3.
- R11: While busy, writes to every register are ignored except the error-clear bit 3 of control, and buffer accesses neither change data nor move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (advances buffer pointer on address 4) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from address |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The execute write is the edge where two functions meet. On that same edge the transfer is launched and the receive count is cut back to fit the buffer, with the error flag set. The bench provokes this by loading 70 transmit bytes with a receive count of 5, so the start edge must both begin the frame and clip the count to 2. The result is judged at the pins and through the registers: the responder must see exactly 73 bytes with zeros on the data-out line after byte 71, the receive count must read back as 2 with the error bit set, and offsets 70 and 71 must hold the responder's bytes.

// File: rtl/spi_cmd_pkg.sv
// Package: shared register map, control bit positions and sequencer states
// for the SPI flash command engine. Assumes an 8-bit host data path.
package spi_cmd_pkg;

    localparam int HOST_AW = 3;
    localparam int HOST_DW = 8;

    localparam logic [HOST_AW-1:0] ADR_OPCODE = 3'd0;
    localparam logic [HOST_AW-1:0] ADR_CTRL   = 3'd1;
    localparam logic [HOST_AW-1:0] ADR_XIDX   = 3'd2;
    localparam logic [HOST_AW-1:0] ADR_XDATA  = 3'd3;
    localparam logic [HOST_AW-1:0] ADR_FIFO   = 3'd4;
    localparam logic [HOST_AW-1:0] ADR_DIV    = 3'd5;

    // control write bits
    localparam int CTL_EXEC    = 0;
    localparam int CTL_PTR_RST = 1;
    localparam int CTL_ERR_CLR = 3;
    // status read bits
    localparam int STS_EXEC = 0;
    localparam int STS_BUSY = 1;
    localparam int STS_ERR  = 2;

    // extension index values decoded by the count registers
    localparam logic [HOST_DW-1:0] XIDX_TXCNT = 8'd5;
    localparam logic [HOST_DW-1:0] XIDX_RXCNT = 8'd6;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LEAD  = 2'd1,
        SEQ_SHIFT = 2'd2,
        SEQ_TRAIL = 2'd3
    } seq_state_t;

endpackage

// File: rtl/spi_cmd_clkgen.sv
// Module: half-period tick generator. Emits a one-cycle tick every DIV system
// cycles while enabled (DIV of 0 behaves as 1). Counter restarts when disabled.
module spi_cmd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_len;

    // effective half-period length, never below one cycle
    always_comb begin
        half_len = (div == '0) ? DIV_W'(1) : div;
        tick     = en && (cnt_q == half_len - DIV_W'(1));
    end

    // count system cycles within the current half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_cmd_fifo.sv
// Module: shared byte buffer. One write port (muxed by the top between host
// and sequencer) and two combinational read ports. Assumes callers keep
// addresses below DEPTH.
module spi_cmd_fifo #(
    parameter int DEPTH = 72,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem_q [DEPTH];

    // single write port
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // asynchronous read ports for host window and sequencer
    always_comb begin
        rdata_a = mem_q[raddr_a];
        rdata_b = mem_q[raddr_b];
    end
endmodule

// File: rtl/spi_cmd_regs.sv
// Module: host register file. Holds opcode, counts (via index/data pair),
// divider, buffer pointer, execute flag and sticky clip error. Assumes one
// host access per cycle; all writes except error-clear are dropped while busy.
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 72,
    parameter int AW    = $clog2(DEPTH),
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               busy,
    input  logic               done,
    output logic               start,
    output logic               exec_flag,
    output logic [7:0]         opcode,
    output logic [7:0]         tx_cnt,
    output logic [7:0]         rx_eff,
    output logic [DIV_W-1:0]   div,
    output logic               hf_we,
    output logic [AW-1:0]      hf_ptr,
    output logic [7:0]         hf_wdata,
    input  logic [7:0]         hf_rdata
);
    localparam logic [7:0]    DEPTH_B = 8'(DEPTH);
    localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

    logic [7:0]       opcode_q;
    logic [7:0]       xidx_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;
    logic [DIV_W-1:0] div_q;
    logic [AW-1:0]    ptr_q;
    logic             exec_q;
    logic             err_q;
    logic             wr_ok;
    logic             fifo_acc;
    logic [7:0]       room;
    logic             rx_clip;
    logic             wdata_big;

    // decode the accepted host operations and the receive-count clip
    always_comb begin
        wr_ok     = host_wr && !busy;
        fifo_acc  = !busy && (host_addr == ADR_FIFO) && (host_wr || host_rd);
        start     = wr_ok && (host_addr == ADR_CTRL) && host_wdata[CTL_EXEC] && !exec_q;
        room      = DEPTH_B - tx_q;
        rx_clip   = rx_q > room;
        rx_eff    = rx_clip ? room : rx_q;
        wdata_big = host_wdata > DEPTH_B;
        hf_we     = wr_ok && (host_addr == ADR_FIFO);
        hf_wdata  = host_wdata;
        hf_ptr    = ptr_q;
        opcode    = opcode_q;
        tx_cnt    = tx_q;
        div       = div_q;
        exec_flag = exec_q;
    end

    // configuration registers: opcode, index, divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            xidx_q   <= '0;
            div_q    <= DIV_W'(1);
        end else if (wr_ok) begin
            case (host_addr)
                ADR_OPCODE: opcode_q <= host_wdata;
                ADR_XIDX:   xidx_q   <= host_wdata;
                ADR_DIV:    div_q    <= DIV_W'(host_wdata);
                default: ;
            endcase
        end
    end

    // byte counts, clipped to buffer size on write and on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (start) begin
            rx_q <= rx_eff;
        end else if (wr_ok && host_addr == ADR_XDATA) begin
            if (xidx_q == XIDX_TXCNT) begin
                tx_q <= wdata_big ? DEPTH_B : host_wdata;
            end else if (xidx_q == XIDX_RXCNT) begin
                rx_q <= wdata_big ? DEPTH_B : host_wdata;
            end
        end
    end

    // sticky clip error: cleared by bit 3, set by any clip (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            if (host_wr && host_addr == ADR_CTRL && host_wdata[CTL_ERR_CLR]) begin
                err_q <= 1'b0;
            end
            if (start && rx_clip) begin
                err_q <= 1'b1;
            end
            if (wr_ok && host_addr == ADR_XDATA && wdata_big &&
                (xidx_q == XIDX_TXCNT || xidx_q == XIDX_RXCNT)) begin
                err_q <= 1'b1;
            end
        end
    end

    // execute flag: set at start, dropped when the sequencer finishes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= 1'b0;
        end else if (start) begin
            exec_q <= 1'b1;
        end else if (done) begin
            exec_q <= 1'b0;
        end
    end

    // buffer pointer: rewind on request, advance on each idle access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_ok && host_addr == ADR_CTRL && host_wdata[CTL_PTR_RST]) begin
            ptr_q <= '0;
        end else if (fifo_acc) begin
            ptr_q <= (ptr_q == LAST_P) ? '0 : ptr_q + AW'(1);
        end
    end

    // read multiplexer
    always_comb begin
        case (host_addr)
            ADR_OPCODE: host_rdata = opcode_q;
            ADR_CTRL:   host_rdata = {5'b0, err_q, busy, exec_q};
            ADR_XIDX:   host_rdata = xidx_q;
            ADR_XDATA:  host_rdata = (xidx_q == XIDX_TXCNT) ? tx_q :
                                     (xidx_q == XIDX_RXCNT) ? rx_q : 8'h00;
            ADR_FIFO:   host_rdata = hf_rdata;
            ADR_DIV:    host_rdata = 8'(div_q);
            default:    host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_cmd_seq.sv
// Module: serial sequencer. Frames opcode, transmit bytes and receive bytes
// in SPI mode 0, MSB first. Byte b (b>=1) of a frame maps to buffer offset
// b-1 for both directions. Assumes count inputs stable for the start cycle.
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 72,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    tx_cnt,
    input  logic [7:0]    rx_eff,
    input  logic          tick,
    input  logic          miso,
    input  logic [7:0]    fifo_rdata,
    output logic [AW-1:0] fifo_raddr,
    output logic          fifo_we,
    output logic [AW-1:0] fifo_waddr,
    output logic [7:0]    fifo_wdata,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    output logic          busy,
    output logic          done
);
    seq_state_t state_q;
    logic [7:0] shreg_q;
    logic [2:0] bitcnt_q;
    logic [7:0] bytecnt_q;
    logic [7:0] tx_l_q;
    logic [7:0] total_q;
    logic       samp_q;
    logic       sclk_q;
    logic       cs_n_q;
    logic [7:0] shifted;
    logic       fall_tick;
    logic       byte_end;
    logic       last_byte;
    logic       in_tx;

    // derived strobes and data path
    always_comb begin
        shifted    = {shreg_q[6:0], samp_q};
        fall_tick  = (state_q == SEQ_SHIFT) && tick && sclk_q;
        byte_end   = fall_tick && (bitcnt_q == 3'd7);
        last_byte  = (bytecnt_q == total_q - 8'd1);
        in_tx      = bytecnt_q <= tx_l_q;
        fifo_raddr = AW'(bytecnt_q);
        fifo_we    = byte_end && !in_tx;
        fifo_waddr = AW'(bytecnt_q - 8'd1);
        fifo_wdata = shifted;
        mosi       = (state_q != SEQ_IDLE) && in_tx && shreg_q[7];
        sclk       = sclk_q;
        cs_n       = cs_n_q;
        busy       = state_q != SEQ_IDLE;
        done       = (state_q == SEQ_TRAIL) && tick;
    end

    // frame state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            shreg_q   <= '0;
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
            tx_l_q    <= '0;
            total_q   <= '0;
            samp_q    <= 1'b0;
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q   <= SEQ_LEAD;
                        cs_n_q    <= 1'b0;
                        sclk_q    <= 1'b0;
                        shreg_q   <= opcode;
                        bitcnt_q  <= '0;
                        bytecnt_q <= '0;
                        tx_l_q    <= tx_cnt;
                        total_q   <= 8'd1 + tx_cnt + rx_eff;
                    end
                end
                SEQ_LEAD: begin
                    if (tick) begin
                        state_q <= SEQ_SHIFT;
                        sclk_q  <= 1'b1;
                        samp_q  <= miso;
                    end
                end
                SEQ_SHIFT: begin
                    if (tick && !sclk_q) begin
                        sclk_q <= 1'b1;
                        samp_q <= miso;
                    end else if (tick) begin
                        sclk_q <= 1'b0;
                        if (bitcnt_q == 3'd7) begin
                            bitcnt_q <= '0;
                            if (last_byte) begin
                                state_q <= SEQ_TRAIL;
                            end else begin
                                bytecnt_q <= bytecnt_q + 8'd1;
                                shreg_q   <= (bytecnt_q < tx_l_q) ? fifo_rdata : 8'h00;
                            end
                        end else begin
                            bitcnt_q <= bitcnt_q + 3'd1;
                            shreg_q  <= shifted;
                        end
                    end
                end
                SEQ_TRAIL: begin
                    if (tick) begin
                        state_q <= SEQ_IDLE;
                        cs_n_q  <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Module: top of the SPI flash command engine. Wires the register file, the
// shared buffer, the half-period tick generator and the serial sequencer.
// The buffer write port belongs to the sequencer while busy, else the host.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 72,
    parameter int DIV_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic             busy_w;
    logic             done_w;
    logic             start_w;
    logic             exec_w;
    logic             tick_w;
    logic [7:0]       opcode_w;
    logic [7:0]       tx_cnt_w;
    logic [7:0]       rx_eff_w;
    logic [DIV_W-1:0] div_w;
    logic             hf_we_w;
    logic [AW-1:0]    hf_ptr_w;
    logic [7:0]       hf_wdata_w;
    logic [7:0]       hf_rdata_w;
    logic             sf_we_w;
    logic [AW-1:0]    sf_waddr_w;
    logic [7:0]       sf_wdata_w;
    logic [AW-1:0]    sf_raddr_w;
    logic [7:0]       sf_rdata_w;
    logic             m_we;
    logic [AW-1:0]    m_waddr;
    logic [7:0]       m_wdata;

    // buffer write-port owner select
    always_comb begin
        m_we    = busy_w ? sf_we_w    : hf_we_w;
        m_waddr = busy_w ? sf_waddr_w : hf_ptr_w;
        m_wdata = busy_w ? sf_wdata_w : hf_wdata_w;
    end

    spi_cmd_regs #(.DEPTH(FIFO_DEPTH), .AW(AW), .DIV_W(DIV_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy_w), .done(done_w), .start(start_w), .exec_flag(exec_w),
        .opcode(opcode_w), .tx_cnt(tx_cnt_w), .rx_eff(rx_eff_w), .div(div_w),
        .hf_we(hf_we_w), .hf_ptr(hf_ptr_w), .hf_wdata(hf_wdata_w),
        .hf_rdata(hf_rdata_w)
    );

    spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW)) fifo_i (
        .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .raddr_a(hf_ptr_w), .rdata_a(hf_rdata_w),
        .raddr_b(sf_raddr_w), .rdata_b(sf_rdata_w)
    );

    spi_cmd_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .en(busy_w), .div(div_w), .tick(tick_w)
    );

    spi_cmd_seq #(.DEPTH(FIFO_DEPTH), .AW(AW)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_w), .opcode(opcode_w),
        .tx_cnt(tx_cnt_w), .rx_eff(rx_eff_w), .tick(tick_w), .miso(spi_miso),
        .fifo_rdata(sf_rdata_w), .fifo_raddr(sf_raddr_w), .fifo_we(sf_we_w),
        .fifo_waddr(sf_waddr_w), .fifo_wdata(sf_wdata_w),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .busy(busy_w), .done(done_w)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
// Module: protocol checker bound to the engine top. Observes pins and the
// internal busy/execute/count nets; drives nothing.
module spi_cmd_engine_chk #(
    parameter int FIFO_DEPTH = 72
) (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       busy,
    input logic       exec_flag,
    input logic [7:0] opcode,
    input logic [7:0] tx_cnt,
    input logic [7:0] rx_eff
);
    assert_sclk_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_mosi);

    assert_exec_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_flag == busy);

    assert_cs_release_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !busy && $past(busy));

    assert_opcode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opcode));

    assert_tx_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= 8'(FIFO_DEPTH));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (9'(tx_cnt) + 9'(rx_eff)) <= 9'(FIFO_DEPTH));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .busy(busy_w), .exec_flag(exec_w),
    .opcode(opcode_w), .tx_cnt(tx_cnt_w), .rx_eff(rx_eff_w)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
    localparam real TCK = 5.0;
    localparam logic [2:0] A_OPC = 3'd0, A_CTL = 3'd1, A_XI = 3'd2,
                           A_XD = 3'd3, A_FIFO = 3'd4, A_DIV = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int  checks = 0;
    int  errors = 0;
    int  frames = 0;
    bit  finished = 0;
    int  exp_half = 1;
    logic [7:0] exp_q[$];
    logic [7:0] tx_buf [72];

    always #(TCK/2) clk = ~clk;

    spi_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp(input int k);
        return 8'(k * 37 + 8'h5A);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    // flash responder and scoreboard monitor
    bit         in_frame = 0;
    bit         first_rise = 0;
    int         bitn = 0;
    logic [7:0] cur = '0;
    realtime    t_csf, t_rise, t_fall;

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            in_frame = 1; first_rise = 1; bitn = 0; cur = '0;
            t_csf = $realtime;
            spi_miso = resp(0)[7];
        end
    end

    always @(posedge spi_sclk) begin
        t_rise = $realtime;
        if (first_rise) begin
            check(near(t_rise - t_csf, exp_half * TCK), "R7 lead time",
                  int'(t_rise - t_csf), int'(exp_half * TCK));
            first_rise = 0;
        end else begin
            check(near(t_rise - t_fall, exp_half * TCK), "R8 low half-period",
                  int'(t_rise - t_fall), int'(exp_half * TCK));
        end
        #1;
        cur = {cur[6:0], spi_mosi};
        bitn++;
        if (bitn % 8 == 0) begin
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected byte", cur, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(cur == e, "R3 mosi byte", cur, e);
            end
        end
    end

    always @(negedge spi_sclk) begin
        t_fall = $realtime;
        check(near(t_fall - t_rise, exp_half * TCK), "R8 high half-period",
              int'(t_fall - t_rise), int'(exp_half * TCK));
        spi_miso = resp(bitn / 8)[7 - (bitn % 8)];
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            in_frame = 0;
            frames++;
            check(near($realtime - t_fall, exp_half * TCK), "R7 trail time",
                  int'($realtime - t_fall), int'(exp_half * TCK));
            check(exp_q.size() == 0 && bitn % 8 == 0, "R2 frame length",
                  exp_q.size(), 0);
        end
    end

    // host access tasks
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic set_count(input logic [7:0] idx, input logic [7:0] v);
        wr(A_XI, idx);
        wr(A_XD, v);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(A_CTL, s);
            if (s[1:0] == 2'b00) break;
        end
        check(s[1:0] == 2'b00 && spi_cs_n, "R6 idle after frame", s, 0);
    endtask

    // driver: program a command, push expected serial bytes, execute
    task automatic run_cmd(input logic [7:0] opc, input int ntx, input int nrx_wr,
                           input int nrx_exp, input int div);
        wr(A_DIV, 8'(div));
        exp_half = (div == 0) ? 1 : div;
        wr(A_OPC, opc);
        set_count(8'd5, 8'(ntx));
        set_count(8'd6, 8'(nrx_wr));
        wr(A_CTL, 8'h02);
        for (int i = 0; i < ntx; i++) wr(A_FIFO, tx_buf[i]);
        exp_q.push_back(opc);
        for (int i = 0; i < ntx; i++) exp_q.push_back(tx_buf[i]);
        for (int i = 0; i < nrx_exp; i++) exp_q.push_back(8'h00);
        wr(A_CTL, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int f0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && spi_mosi === 1'b0,
              "R1 pins at reset", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
        rd(A_CTL, d); check(d == 8'h00, "R1 status", d, 0);
        rd(A_DIV, d); check(d == 8'h01, "R1 divider", d, 1);
        wr(A_XI, 8'd5); rd(A_XD, d); check(d == 0, "R1 tx count", d, 0);
        wr(A_XI, 8'd6); rd(A_XD, d); check(d == 0, "R1 rx count", d, 0);

        // R2 opcode-only command
        run_cmd(8'h06, 0, 0, 0, 2);
        rd(A_CTL, d); check(d[1:0] == 2'b11, "R6 exec and busy during frame", d, 3);
        wait_idle();

        // R3 write command with 24-bit address and data
        tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56;
        tx_buf[3] = 8'hA5; tx_buf[4] = 8'h3C;
        run_cmd(8'h02, 5, 0, 0, 2);
        wait_idle();
        wr(A_CTL, 8'h02);
        for (int i = 0; i < 5; i++) begin
            rd(A_FIFO, d);
            check(d == tx_buf[i], "R9 buffer readback", d, tx_buf[i]);
        end

        // R4 read command: address then 4 receive bytes
        tx_buf[0] = 8'h00; tx_buf[1] = 8'h80; tx_buf[2] = 8'hFF;
        run_cmd(8'h03, 3, 4, 4, 3);
        wait_idle();
        wr(A_CTL, 8'h02);
        for (int i = 0; i < 7; i++) begin
            logic [7:0] e;
            e = (i < 3) ? tx_buf[i] : resp(i + 1);
            rd(A_FIFO, d);
            check(d == e, "R4 response placement", d, e);
        end

        // R8 divider 0 acts as 1; ID-style read with no transmit bytes
        run_cmd(8'h9F, 0, 3, 3, 0);
        wait_idle();
        wr(A_CTL, 8'h02);
        for (int i = 0; i < 3; i++) begin
            rd(A_FIFO, d);
            check(d == resp(i + 1), "R4 id bytes at offset 0", d, resp(i + 1));
        end

        // R5 unknown index ignored
        set_count(8'd7, 8'h2A);
        rd(A_XD, d); check(d == 0, "R5 unknown index reads 0", d, 0);
        wr(A_XI, 8'd5); rd(A_XD, d); check(d == 0, "R5 tx count untouched", d, 0);
        wr(A_XI, 8'd6); rd(A_XD, d); check(d == 3, "R5 rx count kept", d, 3);

        // R11 / R6 writes and execute ignored while busy
        f0 = frames;
        run_cmd(8'h9F, 0, 8, 8, 4);
        wr(A_OPC, 8'h55);
        wr(A_CTL, 8'h01);
        set_count(8'd5, 8'd9);
        wr(A_DIV, 8'd9);
        wait_idle();
        repeat (100) @(negedge clk);
        check(frames == f0 + 1, "R6 no second frame", frames - f0, 1);
        rd(A_OPC, d); check(d == 8'h9F, "R11 opcode kept", d, 8'h9F);
        rd(A_DIV, d); check(d == 8'd4, "R11 divider kept", d, 4);
        wr(A_XI, 8'd5); rd(A_XD, d); check(d == 0, "R11 tx count kept", d, 0);

        // R10 clip on write, sticky error and clear
        set_count(8'd5, 8'd100);
        rd(A_XD, d); check(d == 72, "R10 tx clipped", d, 72);
        rd(A_CTL, d); check(d[2], "R10 error set", d, 4);
        wr(A_CTL, 8'h08);
        rd(A_CTL, d); check(!d[2], "R10 error cleared", d, 0);

        // R10 clip at start together with launch
        for (int i = 0; i < 70; i++) tx_buf[i] = 8'(i * 3 + 1);
        run_cmd(8'h0B, 70, 5, 2, 1);
        wait_idle();
        wr(A_XI, 8'd6); rd(A_XD, d); check(d == 2, "R10 rx clipped at start", d, 2);
        rd(A_CTL, d); check(d == 8'h04, "R10 error after start clip", d, 4);
        wr(A_CTL, 8'h02);
        for (int i = 0; i < 72; i++) begin
            logic [7:0] e;
            e = (i < 70) ? tx_buf[i] : resp(i + 1);
            rd(A_FIFO, d);
            if (i >= 68) check(d == e, "R10 tail bytes", d, e);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule